// File: doc/BRIEF.md
# PLL configuration and lock timer

This block is the register-facing half of an application clock synthesizer. A host stores a lock-time count and a single configuration word. The configuration word carries an enable flag and the three divider settings: feedback multiplier M, pre-divider P and post-divider scaler S. The block hands the decoded settings to the analog macro. It then models settling by counting reference-clock cycles equal to the stored lock time before it raises a locked flag. The host can poll that flag through the read port.

Every write of the configuration word drops lock and restarts the count from the lock-time register. Software therefore loads the lock time first and then writes the configuration word. With enable clear the block never reports lock. The analog loop and the output frequency are not modelled; only the timing of lock is.

Top module: `pll_cfg_lock`

## Requirements
- R1: After reset `locked` is 0, `m_val`, `p_val` and `s_val` are 0, the configuration register reads 0 and the lock-time register reads LOCK_RST (default 0x2CF, which is 30 us at a 24 MHz reference).
- R2: The configuration register is selected by address 1 and the lock-time register by address 0. In the configuration word the enable flag is bit 31, M is bits [25:16] (10 bits), P is bits [13:8] (6 bits) and S is bits [2:0] (3 bits). `m_val`, `p_val` and `s_val` show the written fields from the clock edge that takes the write.
- R3: Reading the configuration register returns the enable flag and the M, P and S fields at their positions. Bit 29 is replaced by the live `locked` value, and all other bits read 0, whatever was written to them.
- R4: With enable 1 and lock time N, `locked` rises on exactly the (N+1)th rising edge after the edge that took the configuration write (N=0 gives lock on the next edge).
- R5: Any configuration write, including a rewrite of the same value, clears `locked` on its edge and restarts the count from the current lock-time value.
- R6: While the enable flag is 0, `locked` stays 0 for any number of cycles and the lock counter holds its value.
- R7: A lock-time write changes neither a count in progress nor `locked`. It takes effect at the next configuration write.
- R8: The lock-time register keeps the low LOCK_W bits of the write (default 16). Upper bits are dropped, and it reads back zero-extended.
- R9: Once set, `locked` stays 1 until the next configuration write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the lock count runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 1 | Write select: 0 lock time, 1 configuration |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 lock time, 1 configuration |
| rd_data | output | 32 | Read data, combinational from rd_addr and register state |
| locked | output | 1 | Lock reached |
| m_val | output | 10 | Decoded M setting |
| p_val | output | 6 | Decoded P setting |
| s_val | output | 3 | Decoded S setting |

## Verification
Writes land on the rising edge that sees `wr_en`. The decoded fields and the readback are therefore due on the half cycle after that edge, and `locked` is due exactly N+1 edges later. The bench drives and samples on falling edges. It counts those edges from the write edge, checks `locked` low one edge before the due edge and high on it, and so pins the exact cycle. The same counting is used for the mid-count lock-time rewrite, for the 720-edge count of the reset default, and for the two-edge delay of the reset release.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int WORD_W  = 32;
  localparam int EN_POS  = 31;
  localparam int LK_POS  = 29;
  localparam int M_LSB   = 16;
  localparam int M_W     = 10;
  localparam int P_LSB   = 8;
  localparam int P_W     = 6;
  localparam int S_LSB   = 0;
  localparam int S_W     = 3;

  localparam logic SEL_LOCKT = 1'b0;
  localparam logic SEL_CFG   = 1'b1;

  typedef struct packed {
    logic           en;
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
  } pll_cfg_t;

  function automatic pll_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
    pll_cfg_t c;
    c.en = w[EN_POS];
    c.m  = w[M_LSB +: M_W];
    c.p  = w[P_LSB +: P_W];
    c.s  = w[S_LSB +: S_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_pack(input pll_cfg_t c, input logic lk);
    logic [WORD_W-1:0] w;
    w                = '0;
    w[EN_POS]        = c.en;
    w[LK_POS]        = lk;
    w[M_LSB +: M_W]  = c.m;
    w[P_LSB +: P_W]  = c.p;
    w[S_LSB +: S_W]  = c.s;
    return w;
  endfunction

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int              LOCK_W   = 16,
  parameter logic [LOCK_W-1:0] LOCK_RST = 16'h02CF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output pll_cfg_t          cfg_o,
  output logic [LOCK_W-1:0] lock_time_o,
  output logic              cfg_wr_o
);
  pll_cfg_t          cfg_q,  cfg_d;
  logic [LOCK_W-1:0] lt_q,   lt_d;
  logic              cfg_ce, lt_ce;

  always_comb begin
    cfg_ce = wr_en && (wr_addr == SEL_CFG);
    lt_ce  = wr_en && (wr_addr == SEL_LOCKT);
    cfg_d  = cfg_unpack(wr_data);
    lt_d   = wr_data[LOCK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lt_q <= LOCK_RST;
    else if (lt_ce) lt_q <= lt_d;
  end

  assign cfg_o       = cfg_q;
  assign lock_time_o = lt_q;
  assign cfg_wr_o    = cfg_ce;
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic [LOCK_W-1:0] lock_time,
  output logic              locked_o,
  output logic [LOCK_W-1:0] count_o
);
  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              lk_q,  lk_d;
  logic              cnt_ce;
  logic              cnt_zero;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    cnt_d    = cnt_q;
    lk_d     = lk_q;
    cnt_ce   = 1'b0;
    if (restart) begin
      cnt_ce = 1'b1;
      cnt_d  = lock_time;
      lk_d   = 1'b0;
    end else if (enable) begin
      if (!cnt_zero) begin
        cnt_ce = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end else begin
        lk_d   = 1'b1;
      end
    end else begin
      lk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_q <= 1'b0;
    else        lk_q <= lk_d;
  end

  assign locked_o = lk_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux
  import pll_cfg_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic              rd_addr,
  input  pll_cfg_t          cfg,
  input  logic              locked,
  input  logic [LOCK_W-1:0] lock_time,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == SEL_CFG) rd_data = cfg_pack(cfg, locked);
    else                    rd_data[LOCK_W-1:0] = lock_time;
  end
endmodule

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock
  import pll_cfg_pkg::*;
#(
  parameter int                LOCK_W   = 16,
  parameter logic [LOCK_W-1:0] LOCK_RST = 16'h02CF
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              locked,
  output logic [M_W-1:0]    m_val,
  output logic [P_W-1:0]    p_val,
  output logic [S_W-1:0]    s_val
);
  logic              rst_n_sync;
  pll_cfg_t          cfg;
  logic [LOCK_W-1:0] lock_time;
  logic              cfg_wr;
  logic              cfg_en;
  logic [LOCK_W-1:0] lock_cnt;

  pll_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk_ref),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  pll_cfg_regs #(.LOCK_W(LOCK_W), .LOCK_RST(LOCK_RST)) u_regs (
    .clk         (clk_ref),
    .rst_n       (rst_n_sync),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cfg_o       (cfg),
    .lock_time_o (lock_time),
    .cfg_wr_o    (cfg_wr)
  );

  assign cfg_en = cfg.en;

  pll_lock_timer #(.LOCK_W(LOCK_W)) u_timer (
    .clk       (clk_ref),
    .rst_n     (rst_n_sync),
    .restart   (cfg_wr),
    .enable    (cfg_en),
    .lock_time (lock_time),
    .locked_o  (locked),
    .count_o   (lock_cnt)
  );

  pll_rd_mux #(.LOCK_W(LOCK_W)) u_rd (
    .rd_addr   (rd_addr),
    .cfg       (cfg),
    .locked    (locked),
    .lock_time (lock_time),
    .rd_data   (rd_data)
  );

  assign m_val = cfg.m;
  assign p_val = cfg.p;
  assign s_val = cfg.s;
endmodule

// File: rtl/pll_cfg_lock_chk.sv
module pll_cfg_lock_chk #(
  parameter int LOCK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic              rd_addr,
  input logic [31:0]       rd_data,
  input logic              locked,
  input logic              cfg_en,
  input logic [LOCK_W-1:0] lock_cnt,
  input logic [9:0]        m_val
);
  logic cfg_write;
  assign cfg_write = wr_en && wr_addr;

  // R5
  a_r5_write_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> !locked);

  // R6
  a_r6_disabled_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg_write) |=> !locked);

  // R6
  a_r6_disabled_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg_write) |=> $stable(lock_cnt));

  // R9
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cfg_write) |=> locked);

  // R4
  a_r4_lock_only_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && lock_cnt != '0) |=> !locked);

  // R3
  a_r3_live_lock_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> (rd_data[29] == locked));

  // R2
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write |=> $stable(m_val));
endmodule

bind pll_cfg_lock pll_cfg_lock_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n_sync),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .locked   (locked),
  .cfg_en   (cfg_en),
  .lock_cnt (lock_cnt),
  .m_val    (m_val)
);

// File: tb/pll_cfg_lock_tb_top.sv
`timescale 1ns/1ps
module pll_cfg_lock_tb_top;
  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_addr;
  logic [31:0] wr_data;
  logic        rd_addr;
  logic [31:0] rd_data;
  logic        locked;
  logic [9:0]  m_val;
  logic [5:0]  p_val;
  logic [2:0]  s_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk_ref = ~clk_ref;

  pll_cfg_lock dut_i (
    .clk_ref (clk_ref), .rst_n (rst_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .locked (locked), .m_val (m_val), .p_val (p_val), .s_val (s_val)
  );

  // {cfg word, lock time, M, P, S, readback while unlocked}
  localparam int NV = 5;
  localparam logic [98:0] VEC [NV] = '{
    {32'h807D_0301, 16'd3, 10'd125,  6'd3,  3'd1, 32'h807D_0301},
    {32'h8064_0301, 16'd5, 10'd100,  6'd3,  3'd1, 32'h8064_0301},
    {32'h83FF_3F07, 16'd0, 10'd1023, 6'd63, 3'd7, 32'h83FF_3F07},
    {32'hA055_2A05, 16'd1, 10'd85,   6'd42, 3'd5, 32'h8055_2A05},
    {32'hFC00_C0F8, 16'd2, 10'd0,    6'd0,  3'd0, 32'h8000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_ref);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    edges(2);
    rst_n = 1'b1;
    edges(3);
  endtask

  initial begin : wdog
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 1'b0;
    @(negedge clk_ref);
    // R1 reset state
    chk("R1 locked", {31'd0, locked}, 32'd0);
    chk("R1 fields", {13'd0, m_val, p_val, s_val}, 32'd0);
    rd(1'b1, v); chk("R1 cfg read", v, 32'd0);
    rd(1'b0, v); chk("R1 lock-time read", v, 32'h0000_02CF);
    edges(1);
    rst_n = 1'b1;
    edges(3);

    // R1 default lock time 0x2CF -> lock on edge 720
    wr(1'b1, 32'h8064_0301);
    edges(719);
    chk("R1 R4 default lock not early", {31'd0, locked}, 32'd0);
    edges(1);
    chk("R1 R4 default lock on time", {31'd0, locked}, 32'd1);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic [31:0] word, rb;
      logic [15:0] n;
      logic [9:0]  em; logic [5:0] ep; logic [2:0] es;
      {word, n, em, ep, es, rb} = VEC[i];
      wr(1'b0, {16'd0, n});
      wr(1'b1, word);
      chk($sformatf("R2 m vec%0d", i), {22'd0, m_val}, {22'd0, em});
      chk($sformatf("R2 p vec%0d", i), {26'd0, p_val}, {26'd0, ep});
      chk($sformatf("R2 s vec%0d", i), {29'd0, s_val}, {29'd0, es});
      rd(1'b1, v); chk($sformatf("R3 readback unlocked vec%0d", i), v, rb);
      edges(n);
      chk($sformatf("R4 not yet locked vec%0d", i), {31'd0, locked}, 32'd0);
      edges(1);
      chk($sformatf("R4 locked vec%0d", i), {31'd0, locked}, 32'd1);
      rd(1'b1, v); chk($sformatf("R3 readback locked vec%0d", i), v, rb | 32'h2000_0000);
    end

    // R9 lock stays
    edges(20);
    chk("R9 lock held", {31'd0, locked}, 32'd1);

    // R5 rewrite of same word restarts
    wr(1'b0, 32'd4);
    wr(1'b1, 32'h807D_0301);
    edges(6);
    chk("R5 first lock", {31'd0, locked}, 32'd1);
    wr(1'b1, 32'h807D_0301);
    chk("R5 lock cleared by rewrite", {31'd0, locked}, 32'd0);
    edges(4);
    chk("R5 restart not early", {31'd0, locked}, 32'd0);
    edges(1);
    chk("R5 restart relock", {31'd0, locked}, 32'd1);

    // R6 enable clear
    wr(1'b0, 32'd2);
    wr(1'b1, 32'h007D_0301);
    chk("R6 lock dropped", {31'd0, locked}, 32'd0);
    edges(30);
    chk("R6 never locks", {31'd0, locked}, 32'd0);
    chk("R6 fields still decoded", {22'd0, m_val}, 32'd125);
    rd(1'b1, v); chk("R6 readback", v, 32'h007D_0301);

    // R7 lock-time write mid count
    wr(1'b0, 32'd6);
    wr(1'b1, 32'h8064_0301);
    edges(2);
    wr(1'b0, 32'd1);
    edges(3);
    chk("R7 count unchanged, not early", {31'd0, locked}, 32'd0);
    edges(1);
    chk("R7 lock at original count", {31'd0, locked}, 32'd1);
    wr(1'b0, 32'd9);
    chk("R7 lock kept over lock-time write", {31'd0, locked}, 32'd1);

    // R8 width truncation
    wr(1'b0, 32'hABCD_1234);
    rd(1'b0, v); chk("R8 lock-time truncated", v, 32'h0000_1234);

    // R1 reset mid run
    rst_n = 1'b0;
    #1;
    chk("R1 async reset lock", {31'd0, locked}, 32'd0);
    chk("R1 async reset fields", {13'd0, m_val, p_val, s_val}, 32'd0);
    rd(1'b0, v); chk("R1 lock-time after reset", v, 32'h0000_02CF);
    edges(2);
    rst_n = 1'b1;
    edges(3);
    rd(1'b1, v); chk("R1 cfg after reset", v, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule